// File: doc/BRIEF.md
# Transmit Descriptor Chain Sequencer

This block walks a ring of transmit descriptors held in memory. Each descriptor is a single 32-bit word placed on a 16-byte grid. It carries an ownership (valid) bit, a last-buffer-of-frame bit, an end-of-ring bit and a buffer length. For every descriptor that software owns, the sequencer asks a data mover to send the buffer. When the buffer has been sent, it writes the word back with ownership returned to software and a completion status bit set. It then moves on to the next descriptor.

There are two modes. In single-buffer mode every descriptor holds one whole frame. In multi-buffer mode a frame spans descriptors until one has its last bit set. In that mode the sequencer reads the next descriptor to decide whether transmission has finished. Two sticky interrupt-source flags separate the two outcomes. One reports normal completion. The other reports that the chain ran out of descriptors in the middle of a frame, which leaves the frame incomplete.

When the sequencer reads a descriptor it does not own, it stops. It reads memory again only after the next transmit-request strobe, and it resumes at that same descriptor.

Top module: `txd_chain_seq`

## Requirements
- R1: After reset `dm_req`, `mv_req`, `tc_flag` and `tde_flag` are all 0, and no memory access happens until `tx_req` is pulsed.
- R2: The first read after reset is at `ring_base`. After the sequencer reads a descriptor with bit 31 clear, it makes no memory access until the next `tx_req` pulse.
- R3: A descriptor read with bit 31 (ownership) set produces exactly one mover request. `mv_len` equals bits 15:0 of that descriptor, and the request stays up, with length and last indication unchanged, until `mv_done`. `dm_req` and `mv_req` are never high together.
- R4: In single-buffer mode (`multi_buf`=0), `mv_last` is 1 whatever the value of bit 30. `tc_flag` is set after the writeback of every descriptor.
- R5: In multi-buffer mode (`multi_buf`=1), `mv_last` equals bit 30. After the writeback of a descriptor with bit 30 set, the sequencer reads the next descriptor. `tc_flag` is set only if that descriptor has bit 31 clear. If it has bit 31 set, the new frame starts with no flag.
- R6: The writeback goes to the address the descriptor was read from. The written word is the read word with bit 31 cleared and bit 28 (done) set.
- R7: If the sequencer reads a descriptor with bit 31 clear while the previous descriptor was not last of its frame (multi-buffer mode), `tde_flag` is set and `tc_flag` is not. A descriptor with bit 31 clear read at a frame boundary sets no flag.
- R8: The descriptor address advances by 16 after each writeback. If the written-back descriptor has bit 29 (end of ring) set, the address returns to `ring_base` instead.
- R9: `tc_flag` and `tde_flag` stay set until `irq_clr` is pulsed, and they are 0 in the cycle after that pulse unless the same event sets them again.
- R10: While `dm_req` waits for `dm_ack`, `dm_addr`, `dm_we` and `dm_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit-request strobe from software |
| multi_buf | input | 1 | 0: one frame per buffer, 1: frames span buffers |
| ring_base | input | ADDR_W | Address of the first descriptor in the ring (16-byte aligned) |
| irq_clr | input | 1 | Clears both flags |
| dm_req | output | 1 | Descriptor memory request |
| dm_we | output | 1 | 1 for writeback, 0 for read |
| dm_addr | output | ADDR_W | Descriptor address |
| dm_wdata | output | 32 | Writeback word |
| dm_ack | input | 1 | Memory accepted the request (read data valid) |
| dm_rdata | input | 32 | Descriptor word read |
| mv_req | output | 1 | Buffer send request to the data mover |
| mv_len | output | LEN_W | Buffer length |
| mv_last | output | 1 | Buffer ends a frame |
| mv_done | input | 1 | Mover finished the buffer |
| tc_flag | output | 1 | Transmit-complete interrupt source |
| tde_flag | output | 1 | Descriptor-exhausted interrupt source |

## Verification
The assertions assume that the memory and the mover each answer only a request that is being held. They assume `dm_ack` and `mv_done` are single-cycle pulses, `ring_base` is aligned to the 16-byte grid, and `multi_buf` does not change while a chain is being walked. The stimulus holds to all of this. The memory model answers after two cycles and the mover after three. `ring_base` is a fixed aligned constant, and `multi_buf` changes only while the block is idle after a run.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_TRANSFER,
    S_WRITEBACK,
    S_CHECK_NEXT
  } seq_state_e;

  localparam int unsigned DESC_W   = 32;
  localparam int unsigned BIT_OWN  = 31;
  localparam int unsigned BIT_LAST = 30;
  localparam int unsigned BIT_EOR  = 29;
  localparam int unsigned BIT_DONE = 28;

  // Word written back once a buffer has gone out: ownership returns to
  // software and the done status bit is raised; all other bits are kept.
  function automatic logic [DESC_W-1:0] wb_word(input logic [DESC_W-1:0] d);
    logic [DESC_W-1:0] w;
    w           = d;
    w[BIT_OWN]  = 1'b0;
    w[BIT_DONE] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/txd_addr_gen.sv
module txd_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic              advance,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic              w
  );
    return w ? b : a + STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_addr <= '0;
    else if (load_base) cur_addr <= base;
    else if (advance)   cur_addr <= step_addr(cur_addr, base, wrap);
  end
endmodule

// File: rtl/txd_irq_flag.sv
module txd_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/txd_seq_fsm.sv
module txd_seq_fsm
  import txd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              multi_buf,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              dm_req,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DESC_W-1:0] dm_wdata,
  input  logic              dm_ack,
  input  logic [DESC_W-1:0] dm_rdata,
  output logic              mv_req,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_last,
  input  logic              mv_done,
  output logic              load_base,
  output logic              advance,
  output logic              wrap,
  output logic              ev_complete,
  output logic              ev_exhaust
);
  seq_state_e        state, state_nx;
  logic [DESC_W-1:0] desc;
  logic              in_frame;
  logic              started;
  logic              rd_owned;
  logic              frame_end;

  assign rd_owned  = dm_rdata[BIT_OWN];
  assign frame_end = desc[BIT_LAST] | ~multi_buf;

  assign dm_req   = (state == S_FETCH) || (state == S_WRITEBACK) || (state == S_CHECK_NEXT);
  assign dm_we    = (state == S_WRITEBACK);
  assign dm_addr  = cur_addr;
  assign dm_wdata = wb_word(desc);
  assign mv_req   = (state == S_TRANSFER);
  assign mv_len   = desc[LEN_W-1:0];
  assign mv_last  = frame_end;

  assign load_base = (state == S_IDLE) && tx_req && !started;
  assign advance   = (state == S_WRITEBACK) && dm_ack;
  assign wrap      = desc[BIT_EOR];

  always_comb begin
    state_nx    = state;
    ev_complete = 1'b0;
    ev_exhaust  = 1'b0;
    unique case (state)
      S_IDLE: if (tx_req) state_nx = S_FETCH;
      S_FETCH: if (dm_ack) begin
        if (rd_owned) state_nx = S_TRANSFER;
        else begin
          ev_exhaust = in_frame;
          state_nx   = S_IDLE;
        end
      end
      S_TRANSFER: if (mv_done) state_nx = S_WRITEBACK;
      S_WRITEBACK: if (dm_ack) begin
        if (frame_end && multi_buf) state_nx = S_CHECK_NEXT;
        else begin
          ev_complete = frame_end;
          state_nx    = S_FETCH;
        end
      end
      S_CHECK_NEXT: if (dm_ack) begin
        if (rd_owned) state_nx = S_TRANSFER;
        else begin
          ev_complete = 1'b1;
          state_nx    = S_IDLE;
        end
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc     <= '0;
      in_frame <= 1'b0;
      started  <= 1'b0;
    end else begin
      state <= state_nx;
      if (load_base) started <= 1'b1;
      if ((state == S_FETCH || state == S_CHECK_NEXT) && dm_ack && rd_owned)
        desc <= dm_rdata;
      if (state == S_FETCH && dm_ack && !rd_owned) in_frame <= 1'b0;
      if (advance) in_frame <= ~frame_end;
    end
  end
endmodule

// File: rtl/txd_chain_seq.sv
module txd_chain_seq #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              multi_buf,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              irq_clr,
  output logic              dm_req,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [31:0]       dm_wdata,
  input  logic              dm_ack,
  input  logic [31:0]       dm_rdata,
  output logic              mv_req,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_last,
  input  logic              mv_done,
  output logic              tc_flag,
  output logic              tde_flag
);
  localparam int NFLAG = 2;

  logic [ADDR_W-1:0] cur_addr;
  logic              load_base, advance, wrap;
  logic              ev_complete, ev_exhaust;
  logic [NFLAG-1:0]  flag_set, flag_q;

  txd_seq_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .multi_buf(multi_buf),
    .cur_addr(cur_addr), .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_ack(dm_ack), .dm_rdata(dm_rdata),
    .mv_req(mv_req), .mv_len(mv_len), .mv_last(mv_last), .mv_done(mv_done),
    .load_base(load_base), .advance(advance), .wrap(wrap),
    .ev_complete(ev_complete), .ev_exhaust(ev_exhaust)
  );

  txd_addr_gen #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_base(load_base), .advance(advance),
    .wrap(wrap), .base(ring_base), .cur_addr(cur_addr)
  );

  assign flag_set = {ev_exhaust, ev_complete};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    txd_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[i]), .clr(irq_clr), .q(flag_q[i])
    );
  end

  assign tc_flag  = flag_q[0];
  assign tde_flag = flag_q[1];
endmodule

// File: rtl/txd_chain_seq_chk.sv
module txd_chain_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_clr,
  input logic              dm_req,
  input logic              dm_we,
  input logic [ADDR_W-1:0] dm_addr,
  input logic [31:0]       dm_wdata,
  input logic              dm_ack,
  input logic              mv_req,
  input logic [LEN_W-1:0]  mv_len,
  input logic              mv_last,
  input logic              mv_done,
  input logic              tc_flag,
  input logic              tde_flag,
  input logic              ev_complete,
  input logic              ev_exhaust
);
  localparam int ALIGN = $clog2(STRIDE);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_req && mv_req));

  assert_mover_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_done |=> mv_req && $stable(mv_len) && $stable(mv_last));

  assert_wb_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req && dm_we |-> !dm_wdata[31] && dm_wdata[28]);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req && !dm_ack |=> dm_req && $stable(dm_addr) && $stable(dm_we) && $stable(dm_wdata));

  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req |-> dm_addr[ALIGN-1:0] == '0);

  assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag && !irq_clr |=> tc_flag);

  assert_tde_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tde_flag && !irq_clr |=> tde_flag);

  assert_tde_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tde_flag) |-> $past(ev_exhaust));

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_exhaust && ev_complete));
endmodule

bind txd_chain_seq txd_chain_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .dm_req(dm_req), .dm_we(dm_we),
  .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_ack(dm_ack), .mv_req(mv_req),
  .mv_len(mv_len), .mv_last(mv_last), .mv_done(mv_done), .tc_flag(tc_flag),
  .tde_flag(tde_flag), .ev_complete(ev_complete), .ev_exhaust(ev_exhaust)
);

// File: tb/txd_chain_seq_tb.sv
`timescale 1ns/1ps
module txd_chain_seq_tb;
  localparam logic [15:0] BASE = 16'h0100;
  localparam int NDESC = 8;

  logic        clk = 0, rst_n = 0, tx_req = 0, multi_buf = 0, irq_clr = 0;
  logic        dm_req, dm_we, dm_ack = 0, mv_req, mv_last, mv_done = 0;
  logic [15:0] dm_addr, mv_len;
  logic [31:0] dm_wdata, dm_rdata = 0;
  logic        tc_flag, tde_flag;

  txd_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .multi_buf(multi_buf),
    .ring_base(BASE), .irq_clr(irq_clr), .dm_req(dm_req), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_ack(dm_ack), .dm_rdata(dm_rdata),
    .mv_req(mv_req), .mv_len(mv_len), .mv_last(mv_last), .mv_done(mv_done),
    .tc_flag(tc_flag), .tde_flag(tde_flag)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit reported = 0;

  logic [31:0] mem [NDESC];
  int          cur_idx = 0;
  int          q_idx[$];
  logic [15:0] q_len[$];
  bit          q_last[$];
  logic [31:0] q_word[$];
  int          w_idx[$];
  logic [31:0] w_word[$];
  bit          exp_tc, exp_tde, run_multi;
  int          run_req, n_access;
  logic [15:0] last_rd_addr, held_addr;
  bit          held_we, mem_phase;
  int          mv_cnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      report();
      $finish;
    end
  end

  // Memory model: answers each request on the second negedge it is seen.
  always @(negedge clk) begin
    if (!rst_n) begin
      dm_ack = 0; mem_phase = 0;
    end else if (dm_req && !dm_ack) begin
      if (!mem_phase) begin
        held_addr = dm_addr; held_we = dm_we; mem_phase = 1;
      end else begin
        int idx;
        chk(dm_addr == held_addr && dm_we == held_we, "R10", "request held",
            dm_addr, held_addr);
        idx = int'((dm_addr - BASE) >> 4) % NDESC;
        n_access++;
        if (dm_we) begin
          if (w_idx.size() == 0) chk(0, "R6", "unexpected writeback", idx, -1);
          else begin
            int ei; logic [31:0] ew;
            ei = w_idx.pop_front(); ew = w_word.pop_front();
            chk(idx == ei, "R6", "writeback index", idx, ei);
            chk(dm_wdata == ew, "R6", "writeback word", dm_wdata, ew);
          end
          mem[idx] = dm_wdata;
        end else begin
          dm_rdata = mem[idx];
          last_rd_addr = dm_addr;
        end
        dm_ack = 1; mem_phase = 0;
      end
    end else dm_ack = 0;
  end

  // Mover model: done pulse on the third negedge of a request.
  always @(negedge clk) begin
    if (!rst_n) begin
      mv_done = 0; mv_cnt = 0;
    end else begin
      chk(!(dm_req && mv_req), "R3", "memory and mover overlap", {dm_req, mv_req}, 0);
      if (mv_req && !mv_done) begin
        if (mv_cnt == 0) begin
          if (q_len.size() == 0) chk(0, "R3", "unexpected mover request", mv_len, -1);
          else begin
            logic [15:0] el; bit elast; bit etc;
            el = q_len.pop_front(); elast = q_last.pop_front();
            void'(q_idx.pop_front());
            etc = !run_multi && run_req > 0;
            chk(mv_len == el, "R3", "mover length", mv_len, el);
            chk(mv_last == elast, run_multi ? "R5" : "R4", "mover last", mv_last, elast);
            chk(tc_flag == etc, run_multi ? "R5" : "R4", "tc during chain", tc_flag, etc);
            run_req++;
          end
        end
        mv_cnt++;
        if (mv_cnt == 3) begin mv_done = 1; mv_cnt = 0; end
      end else mv_done = 0;
    end
  end

  task automatic put(input int idx, input bit own, input bit last, input logic [15:0] len);
    mem[idx] = {own, last, (idx == NDESC - 1), 13'h0, len};
  endtask

  // Behavioural expectation from the requirements, walking the bench's memory.
  task automatic predict(input bit multi);
    int idx = cur_idx;
    bit in_frame = 0;
    exp_tc = 0; exp_tde = 0;
    for (int g = 0; g < 4 * NDESC; g++) begin
      logic [31:0] d; bit lst; int nidx;
      d = mem[idx];
      if (!d[31]) begin
        if (in_frame) exp_tde = 1;
        break;
      end
      lst  = d[30] | !multi;
      nidx = d[29] ? 0 : (idx + 1) % NDESC;
      q_idx.push_back(idx); q_len.push_back(d[15:0]); q_last.push_back(lst);
      w_idx.push_back(idx); w_word.push_back((d & ~32'h8000_0000) | 32'h1000_0000);
      idx = nidx;
      if (lst) begin
        in_frame = 0;
        if (!multi) exp_tc = 1;
        else if (!mem[nidx][31]) begin exp_tc = 1; break; end
      end else in_frame = 1;
    end
    cur_idx = idx;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    for (int c = 0; c < 3000 && quiet < 10; c++) begin
      @(negedge clk);
      if (!dm_req && !mv_req) quiet++; else quiet = 0;
    end
    chk(quiet >= 10, "R2", "sequencer went idle", quiet, 10);
  endtask

  task automatic run(input bit multi, input string req);
    pulse_clr();
    multi_buf = multi; run_multi = multi; run_req = 0;
    predict(multi);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
    wait_quiet();
    chk(q_len.size() == 0, "R3", "all buffers requested", q_len.size(), 0);
    chk(w_idx.size() == 0, "R6", "all writebacks seen", w_idx.size(), 0);
    chk(tc_flag == exp_tc, req, "tc_flag after run", tc_flag, exp_tc);
    chk(tde_flag == exp_tde, "R7", "tde_flag after run", tde_flag, exp_tde);
    chk(last_rd_addr == BASE + 16'(cur_idx * 16), "R8", "stop address",
        last_rd_addr, BASE + 16'(cur_idx * 16));
  endtask

  initial begin
    int acc;
    for (int i = 0; i < NDESC; i++) put(i, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!dm_req && !mv_req, "R1", "no requests after reset", {dm_req, mv_req}, 0);
    chk(!tc_flag && !tde_flag, "R1", "flags after reset", {tc_flag, tde_flag}, 0);
    chk(n_access == 0, "R1", "no access before tx_req", n_access, 0);

    // Empty ring: first read at base, no flag at a frame boundary.
    run(0, "R7");
    chk(last_rd_addr == BASE, "R2", "first read at ring base", last_rd_addr, BASE);

    // Single-buffer mode, last bit ignored.
    put(0, 1, 0, 16'd40); put(1, 1, 1, 16'd64); put(2, 1, 0, 16'd8);
    run(0, "R4");

    // Multi-buffer frame then ring empty: completion.
    put(3, 1, 0, 16'd100); put(4, 1, 1, 16'd20);
    run(1, "R5");

    // Multi-buffer frame cut short: exhaustion.
    put(5, 1, 0, 16'd7);
    run(1, "R7");
    chk(!tc_flag, "R7", "no completion on exhaustion", tc_flag, 0);

    // Two frames across the ring end, wrapping to base.
    put(6, 1, 0, 16'd11); put(7, 1, 1, 16'd12); put(0, 1, 0, 16'd13); put(1, 1, 1, 16'd14);
    run(1, "R5");
    chk(cur_idx == 2, "R8", "walk wrapped through base", cur_idx, 2);

    // Idle after stop: no access without tx_req.
    acc = n_access;
    repeat (30) @(negedge clk);
    chk(n_access == acc, "R2", "no polling without tx_req", n_access, acc);

    // Next descriptor owned after a last buffer: no flag between frames.
    put(2, 1, 1, 16'd30); put(3, 1, 1, 16'd31);
    run(1, "R5");

    // Sticky flags and clearing.
    repeat (20) @(negedge clk);
    chk(tc_flag, "R9", "tc held without clear", tc_flag, 1);
    pulse_clr();
    chk(!tc_flag && !tde_flag, "R9", "flags cleared", {tc_flag, tde_flag}, 0);

    report();
    $finish;
  end
endmodule